// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block turns two active-low external interrupt pins into two request flags for a downstream priority and vector controller. It also merges the serial receive-done and transmit-done bits into one serial interrupt request. Each pin first passes through a clock-domain synchroniser. The synchronised pin is then sampled only on clocks where a machine-cycle strobe is high. A mode bit for each channel chooses how its flag behaves. In edge mode the flag latches a high-to-low transition and holds it until the vector controller acknowledges that channel or software clears it. In level mode the flag follows the sampled pin.

Software can set or clear an edge-mode flag directly. A qualifying edge, or a software set, beats a clear that arrives in the same cycle. Level mode holds the latched flag at zero, so a channel that moves from level to edge mode starts with no stale request. The serial request has no hardware clear: it stays high as long as either done bit is high.

Top module: `xirq_flag_unit`

## Requirements
- R1: Each pin passes through a two-stage synchroniser that resets high. A pin change reaches the sample registers no earlier than the second rising clock edge after it occurs.
- R2: Samples are taken only on rising clock edges where `mcEn` is high. A low pulse that has ended before any strobed sample sees it sets no flag.
- R3: In edge mode (`edgeMode[i]`=1), channel i's flag is set at a strobed edge where the previous sample was high (inactive) and the synchronised pin is now low. The flag is visible on `reqFlag[i]` right after that edge.
- R4: An edge-mode flag stays set while the pin stays low or returns high, until it is cleared.
- R5: A one-cycle `vecAck[i]` pulse clears channel i's edge-mode flag at the next rising edge.
- R6: In level mode (`edgeMode[i]`=0), `reqFlag[i]` is high exactly when the two most recent strobed samples of the pin are both low. `vecAck`, `swSet` and `swClr` have no effect in this mode.
- R7: In edge mode, `swClr[i]` clears and `swSet[i]` sets the flag at the next edge. A qualifying pin edge or `swSet[i]` in the same cycle as a clear (`swClr[i]` or `vecAck[i]`) leaves the flag set.
- R8: Reset clears both flags and loads every synchroniser stage and sample register with the inactive (high) level. A pin that stays high after reset raises no flag.
- R9: A channel that switches from level to edge mode shows `reqFlag[i]`=0 in the first cycle of edge mode.
- R10: `serialReq` is high whenever `rxDone` or `txDone` is high, and no acknowledge or other input of the block clears it.
- R11: The two channels are independent. The pin, mode, acknowledge and software strobes of one channel never change the other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mcEn | input | 1 | Machine-cycle sampling strobe |
| extPinN | input | NUM_CH | External interrupt pins, active low |
| edgeMode | input | NUM_CH | Per-channel mode: 1 edge, 0 level |
| vecAck | input | NUM_CH | Vector-taken acknowledge pulse per channel |
| swClr | input | NUM_CH | Software clear of an edge-mode flag |
| swSet | input | NUM_CH | Software set of an edge-mode flag |
| rxDone | input | 1 | Serial receive-done bit |
| txDone | input | 1 | Serial transmit-done bit |
| reqFlag | output | NUM_CH | Request flags to the priority controller |
| serialReq | output | 1 | Combined serial interrupt request |

## Verification
Most internal faults here show up as timing errors, not as wrong values. A synchroniser stage that is too short or too long moves a flag's rise by one clock. A sample register that ignores `mcEn` shows up as a level-mode flag that changes between strobes. A bad previous-sample reset value raises a flag within three clocks of reset while the pin is idle. A wrong set-versus-clear priority loses a request in the cycle where the edge and the clear coincide. For these reasons the bench compares both outputs against a reference model on every clock. This catches any divergence in the cycle it first appears.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  // Strobes sent from control to the datapath, one set per channel.
  typedef struct packed {
    logic sampleEn;   // take a new sample of the synchronised pin
    logic setFlag;    // force the latched flag high (wins over clear)
    logic clrFlag;    // force the latched flag low
    logic useLatch;   // present the latched flag instead of the level view
  } chStrobe_t;

  // Per-channel state the datapath exposes to control.
  typedef struct packed {
    logic syncLvl;    // synchroniser output (1 = inactive)
    logic newest;     // most recent strobed sample
  } chStatus_t;

endpackage

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic      [NUM_CH-1:0] extPinN,
  input  chStrobe_t [NUM_CH-1:0] ctrl,
  output chStatus_t [NUM_CH-1:0] status,
  output logic      [NUM_CH-1:0] reqFlag
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   newest;
    logic                   older;
    logic                   latched;
    logic                   levelView;

    // Synchroniser: resets to the inactive level so an idle pin shows no edge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '1;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], extPinN[g]};
      end
    end

    // Two-deep sample history, advanced only on machine-cycle strobes.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        newest <= 1'b1;
        older  <= 1'b1;
      end else if (ctrl[g].sampleEn) begin
        newest <= syncChain[LAST_STAGE];
        older  <= newest;
      end
    end

    // Latched request flag: set has priority over clear.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latched <= 1'b0;
      end else if (ctrl[g].setFlag) begin
        latched <= 1'b1;
      end else if (ctrl[g].clrFlag) begin
        latched <= 1'b0;
      end
    end

    always_comb begin
      levelView      = ~newest & ~older;
      reqFlag[g]     = ctrl[g].useLatch ? latched : levelView;
      status[g].syncLvl = syncChain[LAST_STAGE];
      status[g].newest  = newest;
    end
  end

endmodule

// File: rtl/xirq_control.sv
module xirq_control
  import xirq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                   mcEn,
  input  logic      [NUM_CH-1:0] edgeMode,
  input  logic      [NUM_CH-1:0] vecAck,
  input  logic      [NUM_CH-1:0] swClr,
  input  logic      [NUM_CH-1:0] swSet,
  input  logic                   rxDone,
  input  logic                   txDone,
  input  chStatus_t [NUM_CH-1:0] status,
  output chStrobe_t [NUM_CH-1:0] ctrl,
  output logic                   serialReq
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic edgeSeen;

    always_comb begin
      // Previous sample inactive, the value being sampled now active.
      edgeSeen         = mcEn & status[g].newest & ~status[g].syncLvl;
      ctrl[g].sampleEn = mcEn;
      ctrl[g].useLatch = edgeMode[g];
      ctrl[g].setFlag  = edgeMode[g] & (edgeSeen | swSet[g]);
      // Level mode holds the latch empty, so entering edge mode starts clean.
      ctrl[g].clrFlag  = ~edgeMode[g] | vecAck[g] | swClr[g];
    end
  end

  // Serial request: no hardware clear path at all.
  assign serialReq = rxDone | txDone;

endmodule

// File: rtl/xirq_flag_unit.sv
module xirq_flag_unit
  import xirq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcEn,
  input  logic [NUM_CH-1:0] extPinN,
  input  logic [NUM_CH-1:0] edgeMode,
  input  logic [NUM_CH-1:0] vecAck,
  input  logic [NUM_CH-1:0] swClr,
  input  logic [NUM_CH-1:0] swSet,
  input  logic              rxDone,
  input  logic              txDone,
  output logic [NUM_CH-1:0] reqFlag,
  output logic              serialReq
);

  chStrobe_t [NUM_CH-1:0] ctrlBus;
  chStatus_t [NUM_CH-1:0] statusBus;

  xirq_control #(
    .NUM_CH(NUM_CH)
  ) u_ctrl (
    .mcEn      (mcEn),
    .edgeMode  (edgeMode),
    .vecAck    (vecAck),
    .swClr     (swClr),
    .swSet     (swSet),
    .rxDone    (rxDone),
    .txDone    (txDone),
    .status    (statusBus),
    .ctrl      (ctrlBus),
    .serialReq (serialReq)
  );

  xirq_datapath #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .extPinN (extPinN),
    .ctrl    (ctrlBus),
    .status  (statusBus),
    .reqFlag (reqFlag)
  );

endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              mcEn,
  input logic [NUM_CH-1:0] extPinN,
  input logic [NUM_CH-1:0] edgeMode,
  input logic [NUM_CH-1:0] vecAck,
  input logic [NUM_CH-1:0] swClr,
  input logic [NUM_CH-1:0] swSet,
  input logic              rxDone,
  input logic              txDone,
  input logic [NUM_CH-1:0] reqFlag,
  input logic              serialReq
);

  // R10: either done bit keeps the serial request up.
  assert_serial_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone || txDone) |-> serialReq);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R5: acknowledge without a competing set leaves the edge flag low.
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(edgeMode[g]) && edgeMode[g] && $past(vecAck[g]) &&
       !$past(swSet[g]) && !$past(mcEn)) |-> !reqFlag[g]);

    // R2: without a strobe and without software or ack activity, an edge flag holds.
    assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(edgeMode[g]) && edgeMode[g] && !$past(mcEn) && !$past(vecAck[g]) &&
       !$past(swClr[g]) && !$past(swSet[g])) |-> $stable(reqFlag[g]));

    // R6: a level-mode flag changes only after a strobed sample.
    assert_level_no_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(edgeMode[g]) && !edgeMode[g] && !$past(mcEn)) |-> $stable(reqFlag[g]));

    // R7: a software set in edge mode always lands.
    assert_sw_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      ($past(edgeMode[g]) && edgeMode[g] && $past(swSet[g])) |-> reqFlag[g]);

    // R9: first cycle in edge mode carries no stale level request.
    assert_mode_entry_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(edgeMode[g]) |-> !reqFlag[g]);
  end

endmodule

bind xirq_flag_unit xirq_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_xirq_flag_unit.sv
module sim_xirq_flag_unit;

  localparam int  CLK_PERIOD = 10;
  localparam int  NCH        = 2;
  localparam int  RAND_CYCLES = 6000;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           mcEn = 1'b0;
  logic [NCH-1:0] extPinN = '1;
  logic [NCH-1:0] edgeMode = '0;
  logic [NCH-1:0] vecAck = '0;
  logic [NCH-1:0] swClr = '0;
  logic [NCH-1:0] swSet = '0;
  logic           rxDone = 1'b0;
  logic           txDone = 1'b0;
  logic [NCH-1:0] reqFlag;
  logic           serialReq;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_flag_unit #(.NUM_CH(NCH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .extPinN(extPinN),
    .edgeMode(edgeMode), .vecAck(vecAck), .swClr(swClr), .swSet(swSet),
    .rxDone(rxDone), .txDone(txDone), .reqFlag(reqFlag), .serialReq(serialReq)
  );

  // Reference model built from the requirements.
  logic [NCH-1:0] mSyncA, mSyncB, mNew, mOld, mLatch;

  always @(posedge clk) begin
    if (!rstN) begin
      mSyncA = '1; mSyncB = '1; mNew = '1; mOld = '1; mLatch = '0;   // R8
    end else begin
      for (int i = 0; i < NCH; i++) begin
        logic hit;
        hit = mcEn && mNew[i] && !mSyncB[i];                          // R3
        if (!edgeMode[i])                 mLatch[i] = 1'b0;           // R6, R9
        else if (hit || swSet[i])         mLatch[i] = 1'b1;           // R7
        else if (vecAck[i] || swClr[i])   mLatch[i] = 1'b0;           // R5
      end
      if (mcEn) begin                                                 // R2
        mOld = mNew;
        mNew = mSyncB;
      end
      mSyncB = mSyncA;                                                // R1
      mSyncA = extPinN;
    end
  end

  function automatic logic [NCH-1:0] expFlags();
    logic [NCH-1:0] e;
    for (int i = 0; i < NCH; i++)
      e[i] = edgeMode[i] ? mLatch[i] : (!mNew[i] && !mOld[i]);
    return e;
  endfunction

  function automatic logic expSerial();
    return rxDone || txDone;                                          // R10
  endfunction

  task automatic checkVal(string tag, logic [7:0] act, logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one clock and compare against the model at the falling edge.
  task automatic tick(string tag);
    @(negedge clk);
    checkVal({tag, " reqFlag"}, 8'(reqFlag), 8'(expFlags()));
    checkVal("R10 serialReq", 8'(serialReq), 8'(expSerial()));
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state, idle pins raise nothing even with strobes
    checkVal("R8 reset flags", 8'(reqFlag), 8'h0);
    edgeMode = 2'b11; mcEn = 1'b1;
    repeat (5) tick("R8");
    checkVal("R8 idle after reset", 8'(reqFlag), 8'h0);

    // R1/R3: edge on ch0, strobe every clock: visible after third rising edge
    extPinN[0] = 1'b0;
    tick("R1"); tick("R1");
    checkVal("R1 not yet through sync", 8'(reqFlag[0]), 8'h0);
    tick("R3");
    checkVal("R3 edge latched", 8'(reqFlag[0]), 8'h1);
    checkVal("R11 other channel quiet", 8'(reqFlag[1]), 8'h0);
    // R4: holds while low and after release
    repeat (3) tick("R4");
    extPinN[0] = 1'b1;
    repeat (4) tick("R4");
    checkVal("R4 flag held", 8'(reqFlag[0]), 8'h1);
    // R5: acknowledge clears
    vecAck[0] = 1'b1; tick("R5"); vecAck[0] = 1'b0;
    checkVal("R5 ack clear", 8'(reqFlag[0]), 8'h0);

    // R2: short low pulse between strobes is missed
    mcEn = 1'b0;
    extPinN[1] = 1'b0; tick("R2"); extPinN[1] = 1'b1;
    repeat (3) tick("R2");
    mcEn = 1'b1; repeat (3) tick("R2");
    checkVal("R2 pulse missed", 8'(reqFlag[1]), 8'h0);

    // R7: set beats clear, clear alone clears
    swSet[1] = 1'b1; swClr[1] = 1'b1; tick("R7");
    swSet[1] = 1'b0; swClr[1] = 1'b0;
    checkVal("R7 set wins", 8'(reqFlag[1]), 8'h1);
    swClr[1] = 1'b1; tick("R7"); swClr[1] = 1'b0;
    checkVal("R7 sw clear", 8'(reqFlag[1]), 8'h0);

    // R6: level mode needs two low samples; strobes ignored
    edgeMode[1] = 1'b0; extPinN[1] = 1'b0;
    swSet[1] = 1'b1; tick("R6"); swSet[1] = 1'b0;
    tick("R6"); tick("R6");
    checkVal("R6 one sample only", 8'(reqFlag[1]), 8'h0);
    tick("R6");
    checkVal("R6 two samples", 8'(reqFlag[1]), 8'h1);
    vecAck[1] = 1'b1; swClr[1] = 1'b1; tick("R6"); vecAck[1] = 1'b0; swClr[1] = 1'b0;
    checkVal("R6 ack ignored", 8'(reqFlag[1]), 8'h1);

    // R9: switch to edge mode while pin low: no stale request
    edgeMode[1] = 1'b1; tick("R9");
    checkVal("R9 entry clear", 8'(reqFlag[1]), 8'h0);
    extPinN[1] = 1'b1; repeat (3) tick("R9");

    // R10: serial request follows done bits, unaffected by acknowledges
    rxDone = 1'b1; vecAck = 2'b11; tick("R10"); vecAck = '0;
    checkVal("R10 rx only", 8'(serialReq), 8'h1);
    rxDone = 1'b0; txDone = 1'b1; tick("R10");
    checkVal("R10 tx only", 8'(serialReq), 8'h1);
    txDone = 1'b0; tick("R10");

    // Random mix over all requirements, R11 included
    for (int c = 0; c < RAND_CYCLES; c++) begin
      mcEn = ($urandom % 3) == 0;
      for (int i = 0; i < NCH; i++) begin
        if (($urandom % 6) == 0)   extPinN[i]  = ~extPinN[i];
        if (($urandom % 250) == 0) edgeMode[i] = ~edgeMode[i];
        vecAck[i] = ($urandom % 20) == 0;
        swClr[i]  = ($urandom % 30) == 0;
        swSet[i]  = ($urandom % 45) == 0;
      end
      if (($urandom % 10) == 0) rxDone = ~rxDone;
      if (($urandom % 10) == 0) txDone = ~txDone;
      tick("R11 random");
    end
    report();
  end

endmodule